// File: doc/BRIEF.md
# Parallel RGB Panel Sync and Pixel Window Generator

This block drives a parallel RGB panel of 480 by 272 visible pixels. It divides the system clock down to a pixel clock. It counts pixel clocks inside each line and inside each frame, and it produces an active-high line strobe, an active-high frame strobe and a data-enable window. Inside that window it takes one 24-bit pixel per pixel clock from a valid/ready stream and places it on the panel data bus. The bus carries either full 24-bit colour or a reduced 18-bit form.

All timing values sit in loadable registers behind a simple write port. Their reset values suit the target panel. The frame strobe width and the frame period are counted in pixel clocks. The first visible pixel is placed by a horizontal delay counted from the line strobe and a vertical delay, in lines, counted from the frame strobe. A control bit starts and stops generation. Stopping returns the block to the start of a frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset all outputs are low or zero. The timing registers come up with these values: divider 0, line length 525, line strobe width 41, horizontal delay 43, horizontal count 480, vertical delay 12, vertical count 272, frame strobe width 5250, frame period 150150. With these values the first data-enable high appears 2·(6343+1) = 12688 system clock edges after the edge that enables the block.
- R2: `lcd_pclk` is low while the block is disabled. Once enabled, its period is 2·(DIV+1) system clocks. It first rises DIV+1 edges after the enabling edge.
- R3: `lcd_hsync`, `lcd_vsync`, `lcd_de` and `lcd_data` change only at the system edge where `lcd_pclk` falls, or at a disabling edge.
- R4: Number the pixel clocks since enable k = 0, 1, … and let p = k mod frame period. `lcd_hsync` shown for pixel k is high when (p mod line length) < line strobe width.
- R5: `lcd_vsync` shown for pixel k is high when p < frame strobe width. Line position and line index both restart at p = 0, even when the frame period is not a whole number of lines.
- R6: `lcd_de` shown for pixel k is high when h = p mod line length lies in [hdelay, hdelay+hcount) and the line index p / line length lies in [vdelay, vdelay+vcount).
- R7: `pix_ready` is high only in the system cycle whose closing edge is a falling pixel-clock edge, and only for a pixel inside the window. A pixel is taken at that edge when `pix_valid` is high.
- R8: Control bit 1 = 0 puts the pixel on `lcd_data` unchanged. Control bit 1 = 1 drives {6'b0, R[7:2], G[7:2], B[7:2]}, where R = `pix_data`[23:16], G = [15:8] and B = [7:0]. `lcd_data` is zero outside the window.
- R9: If `pix_valid` is low at a window pixel, that pixel is output as zero and `underflow` is set. `underflow` stays set until the block is enabled again from the disabled state.
- R10: Writing control bit 0 = 0 stops the block at that same edge: the strobes, `lcd_de`, `lcd_data` and `lcd_pclk` go low. The next enable restarts at pixel k = 0.
- R11: Register addresses on `cfg_addr` are 0 control (bit 0 enable, bit 1 18-bit mode), 1 divider, 2 line length, 3 line strobe width, 4 horizontal delay, 5 horizontal count, 6 vertical delay, 7 vertical count, 8 frame strobe width, 9 frame period. Loaded values take effect for later pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Input pixel present |
| pix_data | input | 24 | Input pixel, R in [23:16], G in [15:8], B in [7:0] |
| pix_ready | output | 1 | Pixel is taken at the coming edge |
| lcd_pclk | output | 1 | Panel pixel clock |
| lcd_hsync | output | 1 | Line strobe, active high |
| lcd_vsync | output | 1 | Frame strobe, active high |
| lcd_de | output | 1 | Data-enable window |
| lcd_data | output | 24 | Panel pixel data |
| underflow | output | 1 | Sticky missing-pixel flag |

## Verification
The assertions check the following on every cycle:
- the strobes and the data change only when the pixel clock falls, or when the block stops;
- `pix_ready` appears only while enabled and while the pixel clock is high;
- data is zero outside the window;
- the disabled state holds every panel output low;
- a set underflow never clears while running.

The exact positions of the strobes and the window remain for the bench's scenarios. So do a frame period that ends mid-line, the 18-bit packing, the pixel order and the default-timing latency to the first visible pixel. These can only be seen by comparing against the behavioural pixel-index model.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int DIVW = 16,
  parameter int DW = 16,
  parameter int FW = 32,
  parameter int unsigned DEF_DIV = 0,
  parameter int unsigned DEF_LINE = 525,
  parameter int unsigned DEF_HSW = 41,
  parameter int unsigned DEF_HDLY = 43,
  parameter int unsigned DEF_HCNT = 480,
  parameter int unsigned DEF_VDLY = 12,
  parameter int unsigned DEF_VCNT = 272,
  parameter int unsigned DEF_FSW = 5250,
  parameter int unsigned DEF_FSP = 150150
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        pix_valid,
  input  logic [23:0] pix_data,
  output logic        pix_ready,
  output logic        lcd_pclk,
  output logic        lcd_hsync,
  output logic        lcd_vsync,
  output logic        lcd_de,
  output logic [23:0] lcd_data,
  output logic        underflow
);
  logic en_q, m18_q;
  logic [DIVW-1:0] div_q, div_cnt;
  logic [DW-1:0] line_q, hsw_q, hdly_q, hcnt_q, vdly_q, vcnt_q;
  logic [FW-1:0] fsw_q, fsp_q;
  logic [DW-1:0] h_cnt, v_cnt;
  logic [FW-1:0] f_cnt;
  logic pclk_q, hs_q, vs_q, de_q, und_q;
  logic [23:0] dat_q;

  wire wr_ctrl = cfg_we && (cfg_addr == 4'd0);
  wire en_nxt = wr_ctrl ? cfg_wdata[0] : en_q;
  wire en_rise = en_nxt && !en_q;
  wire hit = (div_cnt == div_q);
  wire fall = en_q && hit && pclk_q;

  wire [DW:0] h_end = {1'b0, hdly_q} + {1'b0, hcnt_q};
  wire [DW:0] v_end = {1'b0, vdly_q} + {1'b0, vcnt_q};
  wire act = (h_cnt >= hdly_q) && ({1'b0, h_cnt} < h_end) &&
             (v_cnt >= vdly_q) && ({1'b0, v_cnt} < v_end);
  wire [23:0] fmt = m18_q ? {6'd0, pix_data[23:18], pix_data[15:10], pix_data[7:2]} : pix_data;

  assign pix_ready = fall && act;
  assign lcd_pclk = pclk_q;
  assign lcd_hsync = hs_q;
  assign lcd_vsync = vs_q;
  assign lcd_de = de_q;
  assign lcd_data = dat_q;
  assign underflow = und_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      m18_q <= 1'b0;
      div_q <= DIVW'(DEF_DIV);
      line_q <= DW'(DEF_LINE);
      hsw_q <= DW'(DEF_HSW);
      hdly_q <= DW'(DEF_HDLY);
      hcnt_q <= DW'(DEF_HCNT);
      vdly_q <= DW'(DEF_VDLY);
      vcnt_q <= DW'(DEF_VCNT);
      fsw_q <= FW'(DEF_FSW);
      fsp_q <= FW'(DEF_FSP);
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: begin en_q <= cfg_wdata[0]; m18_q <= cfg_wdata[1]; end
        4'd1: div_q <= cfg_wdata[DIVW-1:0];
        4'd2: line_q <= cfg_wdata[DW-1:0];
        4'd3: hsw_q <= cfg_wdata[DW-1:0];
        4'd4: hdly_q <= cfg_wdata[DW-1:0];
        4'd5: hcnt_q <= cfg_wdata[DW-1:0];
        4'd6: vdly_q <= cfg_wdata[DW-1:0];
        4'd7: vcnt_q <= cfg_wdata[DW-1:0];
        4'd8: fsw_q <= cfg_wdata[FW-1:0];
        4'd9: fsp_q <= cfg_wdata[FW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_nxt || !en_q) begin
      div_cnt <= '0;
      pclk_q <= 1'b0;
    end else if (hit) begin
      div_cnt <= '0;
      pclk_q <= !pclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_nxt) begin
      h_cnt <= '0;
      v_cnt <= '0;
      f_cnt <= '0;
    end else if (fall) begin
      if (f_cnt == fsp_q - FW'(1)) begin
        f_cnt <= '0;
        h_cnt <= '0;
        v_cnt <= '0;
      end else begin
        f_cnt <= f_cnt + 1'b1;
        if (h_cnt == line_q - DW'(1)) begin
          h_cnt <= '0;
          v_cnt <= v_cnt + 1'b1;
        end else begin
          h_cnt <= h_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
      dat_q <= '0;
      und_q <= 1'b0;
    end else if (!en_nxt) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (en_rise) und_q <= 1'b0;
      if (fall) begin
        hs_q <= h_cnt < hsw_q;
        vs_q <= f_cnt < fsw_q;
        de_q <= act;
        dat_q <= (act && pix_valid) ? fmt : 24'd0;
        if (act && !pix_valid) und_q <= 1'b1;
      end
    end
  end
endmodule

module lcd_sync_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        pix_ready,
  input logic        lcd_pclk,
  input logic        lcd_hsync,
  input logic        lcd_vsync,
  input logic        lcd_de,
  input logic [23:0] lcd_data,
  input logic        underflow
);
  AST_OUT_ON_PCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({lcd_hsync, lcd_vsync, lcd_de, lcd_data}) |-> ($fell(lcd_pclk) || !en_q)); // R3
  AST_READY_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (en_q && lcd_pclk)); // R7
  AST_DATA_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_de |-> (lcd_data == 24'd0)); // R8
  AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && en_q) |=> underflow); // R9
  AST_IDLE_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!lcd_hsync && !lcd_vsync && !lcd_de && !lcd_pclk && !pix_ready)); // R10
endmodule

bind lcd_sync_gen lcd_sync_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pix_ready(pix_ready),
  .lcd_pclk(lcd_pclk), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
  .lcd_de(lcd_de), .lcd_data(lcd_data), .underflow(underflow)
);

// File: tb/lcd_sync_gen_tb.sv
`timescale 1ns/1ps
module lcd_sync_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic pix_ready, lcd_pclk, lcd_hsync, lcd_vsync, lcd_de, underflow;
  logic [23:0] lcd_data;

  always #2.5 clk = !clk;

  lcd_sync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .lcd_pclk(lcd_pclk), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_de(lcd_de), .lcd_data(lcd_data), .underflow(underflow)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      if (n_err < 25) $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: pixel index k since enable, position p = k mod frame period
  bit m_en, m_m18;
  longint m_div, m_line, m_hsw, m_hdly, m_hcnt, m_vdly, m_vcnt, m_fsw, m_fsp;
  longint c, k, pos;
  bit e_pclk, e_hs, e_vs, e_de, e_und, e_rdy;
  logic [23:0] e_dat;

  function automatic bit in_win(longint p);
    longint hh = p % m_line;
    longint ln = p / m_line;
    return hh >= m_hdly && hh < m_hdly + m_hcnt && ln >= m_vdly && ln < m_vdly + m_vcnt;
  endfunction

  function automatic logic [23:0] shape(logic [23:0] d, bit m18);
    return m18 ? {6'd0, d[23:18], d[15:10], d[7:2]} : d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_m18 = 0; m_div = 0; m_line = 525; m_hsw = 41; m_hdly = 43;
      m_hcnt = 480; m_vdly = 12; m_vcnt = 272; m_fsw = 5250; m_fsp = 150150;
      c = 0; k = 0; e_pclk = 0; e_hs = 0; e_vs = 0; e_de = 0; e_und = 0; e_rdy = 0; e_dat = '0;
    end else begin
      if (m_en) begin
        c++;
        if (c % (2 * (m_div + 1)) == 0) begin
          pos = k % m_fsp;
          e_hs = (pos % m_line) < m_hsw;
          e_vs = pos < m_fsw;
          e_de = in_win(pos);
          e_dat = (e_de && pix_valid) ? shape(pix_data, m_m18) : 24'd0;
          if (e_de && !pix_valid) e_und = 1;
          k++;
        end
        e_pclk = ((c / (m_div + 1)) % 2) == 1;
      end
      if (cfg_we) begin
        case (cfg_addr)
          4'd0: begin
            if (!cfg_wdata[0]) begin
              m_en = 0; e_pclk = 0; e_hs = 0; e_vs = 0; e_de = 0; e_dat = '0;
            end else if (!m_en) begin
              m_en = 1; c = 0; k = 0; e_und = 0;
            end
            m_m18 = cfg_wdata[1];
          end
          4'd1: m_div = cfg_wdata[15:0];
          4'd2: m_line = cfg_wdata[15:0];
          4'd3: m_hsw = cfg_wdata[15:0];
          4'd4: m_hdly = cfg_wdata[15:0];
          4'd5: m_hcnt = cfg_wdata[15:0];
          4'd6: m_vdly = cfg_wdata[15:0];
          4'd7: m_vcnt = cfg_wdata[15:0];
          4'd8: m_fsw = cfg_wdata;
          4'd9: m_fsp = cfg_wdata;
          default: ;
        endcase
      end
      e_rdy = m_en && ((c + 1) % (2 * (m_div + 1)) == 0) && in_win(k % m_fsp);
    end
  end

  // per-cycle compare, then source drive
  int vpat = 0;
  longint cyc = 0, acc_n = 0;
  logic [27:0] prev_out = '0;
  bit prev_pclk = 0;
  always @(negedge clk) begin
    logic [31:0] t;
    bit v;
    cyc++;
    if (rst_n) begin
      chk("R2 pclk", lcd_pclk, e_pclk);
      chk("R4 hsync", lcd_hsync, e_hs);
      chk("R5 vsync", lcd_vsync, e_vs);
      chk("R6 de", lcd_de, e_de);
      chk("R7 ready", pix_ready, e_rdy);
      chk("R8 data", lcd_data, e_dat);
      chk("R9 underflow", underflow, e_und);
      if ({lcd_hsync, lcd_vsync, lcd_de, lcd_data} != prev_out)
        chk("R3 change off falling edge", (prev_pclk && !lcd_pclk) || !m_en, 1);
    end
    prev_out = {lcd_hsync, lcd_vsync, lcd_de, lcd_data};
    prev_pclk = lcd_pclk;
    v = (vpat == 0) ? 1'b1 : (vpat == 1) ? ((cyc % 5) != 2) : 1'b0;
    t = 32'(acc_n) * 32'h0001_0307 + 32'h005A_3C81;
    pix_valid = v;
    pix_data = t[23:0];
    if (pix_ready && v) acc_n++;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic small_timing(input int dv, input int fp);
    wr(1, dv); wr(2, 20); wr(3, 3); wr(4, 5); wr(5, 10);
    wr(6, 2); wr(7, 4); wr(8, 30); wr(9, fp);
  endtask

  task automatic idle_check();
    chk("R10 hsync low", lcd_hsync, 0);
    chk("R10 vsync low", lcd_vsync, 0);
    chk("R10 de low", lcd_de, 0);
    chk("R10 pclk low", lcd_pclk, 0);
    chk("R10 data zero", lcd_data, 0);
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk("R1 reset outputs", {pix_ready, lcd_pclk, lcd_hsync, lcd_vsync, lcd_de, underflow}, 0);
      chk("R1 reset data", lcd_data, 0);
    end
    rst_n = 1;
    // default timing: latency to first visible pixel
    vpat = 0;
    wr(0, 1);
    while (!lcd_de) @(negedge clk);
    chk("R1 default first de edge", c, 12688);
    repeat (1500) @(negedge clk);
    wr(0, 0);
    idle_check();
    // loaded timing, frame period ending mid-line, 24-bit
    small_timing(1, 150);
    acc_n = 0;
    wr(0, 1);
    repeat (1809) @(negedge clk);
    chk("R11 R6 pixels in three frames", acc_n, 120);
    wr(0, 0);
    idle_check();
    // 18-bit mode with gaps in the stream
    vpat = 1;
    wr(1, 2);
    wr(0, 3);
    repeat (2000) @(negedge clk);
    chk("R9 underflow set", underflow, 1);
    wr(0, 0);
    idle_check();
    repeat (20) @(negedge clk);
    chk("R9 underflow sticky while idle", underflow, 1);
    vpat = 0;
    wr(0, 1);
    chk("R9 underflow cleared on enable", underflow, 0);
    // stop in the middle of a line strobe, then restart
    while (!(lcd_hsync && k > 30)) @(negedge clk);
    wr(0, 0);
    idle_check();
    wr(0, 1);
    repeat (700) @(negedge clk);
    chk("R9 no underflow with full stream", underflow, 0);
    wr(0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule